// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a system clock into the two timing references a UART needs: a one-cycle oversampling pulse (`os_tick`) at sixteen times the bit rate, and a bit-rate clock (`bit_clk`). A gated prescaler divides the input clock by 1, 2, 4 or 8 to form a count-clock enable. An 8-bit down counter runs on that count clock and reloads from `reload_val` each time it underflows. Every underflow gives one `os_tick` pulse.

Integer division alone leaves a rate error. To reduce it, the block adds a fractional step. A 4-bit `fine_val` picks how many of every sixteen consecutive underflows are stretched by one extra count clock. The stretched slots are spread as evenly as the frame allows. One bit time therefore lasts `(reload_val+1)*16 + fine_val` count clocks. A 4-bit slot index walks the sixteen slots of a frame and wraps, so the stretch pattern repeats on every frame. `bit_clk` is low for the first eight pulses of a frame and high for the last eight.

The counter is driven by a three-state machine. In `ST_IDLE` the block is disabled and holds everything cleared. The transition *start* (enable seen) loads the counter and enters `ST_COUNT`. In `ST_COUNT` the counter steps down on each count clock. At zero it takes either *fire* (reload and pulse, staying in `ST_COUNT`) or *stretch* (the current slot is marked for delay, go to `ST_DELAY`). `ST_DELAY` waits exactly one count clock and then takes *release* (reload and pulse, back to `ST_COUNT`). From any state, *stop* (enable low) returns to `ST_IDLE`.

Top module: `frac_baud_gen`

## Requirements
- R1: The count clock is the input clock divided by 1, 2, 4 or 8 for `div_code` values 0, 1, 2 and 3, so with `fine_val`=0 consecutive `os_tick` pulses are `2^div_code * (reload_val+1)` input clocks apart.
- R2: While `rate_en` is 0, `os_tick` and `bit_clk` are 0 from the following cycle on. After `rate_en` rises, the down counter, the slot index and the `bit_clk` phase start from their cleared state, so `bit_clk` first rises together with the 9th `os_tick` pulse.
- R3: An underflow that is not stretched comes `reload_val+1` count clocks after the previous one, and the counter reloads `reload_val` at every underflow.
- R4: The interval between consecutive rising edges of `bit_clk` is `2^div_code * ((reload_val+1)*16 + fine_val)` input clocks.
- R5: Every interval between `os_tick` pulses is either `reload_val+1` or `reload_val+2` count clocks long. Any 16 consecutive intervals contain exactly `fine_val` long ones. A stretch adds exactly one count clock.
- R6: `bit_clk` changes only together with an `os_tick` pulse. It rises with pulse 9 of a frame and falls with pulse 1, exactly 8 pulses after the rise.
- R7: Slot k (0 to 15) of a frame is stretched when floor((k+1)*fine_val/16) > floor(k*fine_val/16). With `fine_val`=0 no slot is stretched, and with `fine_val` of 8 or less no two consecutive intervals are both long.
- R8: During reset, `os_tick` and `bit_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_en | input | 1 | Count clock gate; 0 stops the block and clears its state |
| div_code | input | 2 | Prescaler select: divide by 2^div_code |
| reload_val | input | 8 | Value loaded into the down counter at each underflow |
| fine_val | input | 4 | Number of stretched underflows per 16-slot frame |
| os_tick | output | 1 | One-cycle oversampling pulse at each underflow |
| bit_clk | output | 1 | Bit-rate clock, one period per 16 `os_tick` pulses |

## Verification
The bench runs the generator under several settings. These mix every prescaler code, reload values of 0 (an underflow on every count clock), small values and 255, and fine values of 0, 1, 3, 5, 7, 8 and 15. A fine value of 0 shows the plain integer divider on its own, and each tick gap checks the prescaler and the reload together. Nonzero fine values check that the number of long gaps in a frame equals the fine value, separately from the spread check that rejects adjacent long gaps at low fine values. A reload of 0 with div 1 puts a pulse on every cycle, which stresses the slot index advancing back to back. Measuring whole `bit_clk` periods then confirms the full fractional period, and re-enabling between settings confirms that the phase restarts from a cleared state.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DELAY = 2'd2
    } fbg_state_e;

    // Even spread: slot k stretched when the running share of stretches steps up.
    function automatic logic fbg_is_delayed(input int unsigned fine,
                                            input int unsigned slot,
                                            input int unsigned slots);
        return (((slot + 1) * fine) / slots) != ((slot * fine) / slots);
    endfunction

endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_code_i,
    output logic             cc_tick_o
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask      = ~({PRE_W{1'b1}} << div_code_i);
        cc_tick_o = enable_i && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pre_q <= '0;
        else if (!enable_i) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_tick_o && div_code_i != '0 && $stable(div_code_i)) |-> !$past(cc_tick_o)); // R1

endmodule

// File: rtl/fbg_count_fsm.sv
module fbg_count_fsm
    import fbg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             cc_tick_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             delay_now_i,
    output logic             fire_o,
    output logic             tick16_o
);
    fbg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    // next state: start, fire, stretch, release, stop
    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (enable_i) state_d = ST_COUNT;
            ST_COUNT: if (cc_tick_i && at_zero) begin
                          if (delay_now_i) state_d = ST_DELAY;
                          else             fire_o  = 1'b1;
                      end
            ST_DELAY: if (cc_tick_i) begin
                          state_d = ST_COUNT;
                          fire_o  = 1'b1;
                      end
            default:  state_d = ST_IDLE;
        endcase
        if (!enable_i) begin
            state_d = ST_IDLE;
            fire_o  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter and pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tick16_o <= 1'b0;
        end else if (!enable_i) begin
            cnt_q    <= '0;
            tick16_o <= 1'b0;
        end else begin
            tick16_o <= fire_o;
            unique case (state_q)
                ST_IDLE:  cnt_q <= reload_i;
                ST_COUNT: if (cc_tick_i) begin
                              if (!at_zero)    cnt_q <= cnt_q - 1'b1;
                              else if (fire_o) cnt_q <= reload_i;
                          end
                ST_DELAY: if (cc_tick_i) cnt_q <= reload_i;
                default:  cnt_q <= '0;
            endcase
        end
    end

    AST_RELOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |-> (cnt_q == $past(reload_i))); // R3
    AST_DELAY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && cc_tick_i && enable_i) |=> (state_q == ST_COUNT && tick16_o)); // R5

endmodule

// File: rtl/fbg_slot_ctrl.sv
module fbg_slot_ctrl
    import fbg_pkg::*;
#(
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              fire_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic              delay_now_o,
    output logic              bit_clk_o
);
    localparam int SLOTS = 1 << FINE_W;
    localparam int HALF  = SLOTS / 2;

    logic [FINE_W-1:0] slot_q;

    assign delay_now_o = fbg_is_delayed(32'(fine_i), 32'(slot_q), SLOTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q    <= '0;
            bit_clk_o <= 1'b0;
        end else if (!enable_i) begin
            slot_q    <= '0;
            bit_clk_o <= 1'b0;
        end else if (fire_i) begin
            slot_q    <= slot_q + 1'b1;
            bit_clk_o <= (slot_q >= FINE_W'(HALF));
        end
    end

    AST_BITCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_clk_o) |-> (slot_q == FINE_W'(HALF + 1))); // R6

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int DIV_W  = 2,
    parameter int CNT_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_en,
    input  logic [DIV_W-1:0]  div_code,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [FINE_W-1:0] fine_val,
    output logic              os_tick,
    output logic              bit_clk
);
    logic cc_tick;
    logic fire;
    logic delay_now;

    fbg_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (rate_en),
        .div_code_i (div_code),
        .cc_tick_o  (cc_tick)
    );

    fbg_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (rate_en),
        .cc_tick_i   (cc_tick),
        .reload_i    (reload_val),
        .delay_now_i (delay_now),
        .fire_o      (fire),
        .tick16_o    (os_tick)
    );

    fbg_slot_ctrl #(.FINE_W(FINE_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (rate_en),
        .fire_i      (fire),
        .fine_i      (fine_val),
        .delay_now_o (delay_now),
        .bit_clk_o   (bit_clk)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_en |=> (!os_tick && !bit_clk)); // R2

endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_en = 1'b0;
    logic [1:0] div_code = '0;
    logic [7:0] reload_val = '0;
    logic [3:0] fine_val = '0;
    logic       os_tick;
    logic       bit_clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .rate_en(rate_en), .div_code(div_code),
        .reload_val(reload_val), .fine_val(fine_val),
        .os_tick(os_tick), .bit_clk(bit_clk)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard of bit_clk rising-edge intervals (R4)
    int  mon_rises = 0;
    int  mon_last = 0;
    bit  mon_prev = 1'b0;
    always @(negedge clk) begin
        if (!rate_en) mon_rises = 0;
        else if (bit_clk && !mon_prev) begin
            if (mon_rises > 0 && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check((cyc - mon_last) == e, "R4 bit period", cyc - mon_last, e);
            end
            mon_rises++;
            mon_last = cyc;
        end
        mon_prev = bit_clk;
    end

    task automatic run_cfg(input int d, input int r, input int f);
        int dv, shrt, n, last, lc, rise_n, fall_n, longs, adj, bad, badv;
        bit pb, pl;
        @(negedge clk);
        rate_en = 1'b0;
        div_code = 2'(d); reload_val = 8'(r); fine_val = 4'(f);
        repeat (4) @(negedge clk);
        check(!os_tick && !bit_clk, "R2 outputs idle", {os_tick, bit_clk}, 0);
        dv = 1 << d;
        shrt = dv * (r + 1);
        for (int i = 0; i < 3; i++) exp_q.push_back(dv * ((r + 1) * 16 + f));
        rate_en = 1'b1;
        n = 0; last = 0; lc = 0; rise_n = 0; fall_n = 0;
        longs = 0; adj = 0; bad = 0; badv = 0; pb = 1'b0; pl = 1'b0;
        while (n < 17) begin
            @(negedge clk);
            lc++;
            if (os_tick) begin
                n++;
                if (n >= 2) begin
                    int iv;
                    iv = lc - last;
                    if (iv == shrt + dv) begin
                        longs++;
                        if (pl) adj++;
                        pl = 1'b1;
                    end else if (iv == shrt) pl = 1'b0;
                    else begin bad++; badv = iv; end
                end
                last = lc;
            end
            if (bit_clk && !pb) rise_n = n;
            if (!bit_clk && pb) fall_n = n;
            pb = bit_clk;
        end
        check(rise_n == 9, "R2 first rise at pulse 9", rise_n, 9);
        check(fall_n - rise_n == 8, "R6 high for 8 pulses", fall_n - rise_n, 8);
        if (f == 0) check(bad == 0 && longs == 0, "R1 R3 tick gap", badv, shrt);
        else        check(bad == 0, "R5 gap short or long", badv, shrt);
        check(longs == f, "R5 long gaps per frame", longs, f);
        if (f <= 8) check(adj == 0, "R7 no adjacent long gaps", adj, 0);
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rate_en = 1'b1;
        div_code = 2'd0; reload_val = 8'd2; fine_val = 4'd3;
        repeat (3) @(negedge clk);
        check(!os_tick && !bit_clk, "R8 reset outputs", {os_tick, bit_clk}, 0);
        @(negedge clk);
        rate_en = 1'b0;
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            repeat (30) begin
                @(negedge clk);
                if (os_tick || bit_clk) seen++;
            end
            check(seen == 0, "R2 no activity while disabled", seen, 0);
        end
        run_cfg(0, 0, 0);
        run_cfg(0, 3, 5);
        run_cfg(1, 2, 15);
        run_cfg(2, 1, 8);
        run_cfg(3, 0, 1);
        run_cfg(3, 4, 3);
        run_cfg(0, 0, 15);
        run_cfg(1, 5, 7);
        run_cfg(0, 255, 7);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule